// File: doc/BRIEF.md
# Pre-Bias Aware Soft-Start Sequencer

This block starts up a buck converter whose output may already be charged by an outside source. Once enable is seen, it waits a programmable number of cycles. On the final cycle of that wait it samples the digitized output voltage. It then drives a reference code that starts from the sampled level, not from zero, and moves to the programmed target.

The length of the start-up window is fixed by a ramp-time setting, in clock cycles, whatever level the sample shows. If the sample lies at or below the target, the reference climbs in near-equal steps and lands exactly on the target when the window closes. If the sample lies above the target but not above the overvoltage limit, the reference stays at the sampled level for the whole window with the drivers on. Power-good then rises and the reference steps down to the target at the same rate a normal ramp would use.

If the sample lies above the overvoltage limit, the drivers are never enabled and a fault pulse is raised instead. If the output is above the limit when the window closes, the start-up is abandoned with a fault pulse.

Top module: `ssq_softstart`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the reference is 0 and the driver enable, power-good and fault outputs are all 0.
- R2: After enable is first seen high, the block waits delay+1 clock edges with the drivers off and the reference at 0. The output code is sampled only on the last of these edges, so any value it takes earlier has no effect.
- R3: If the sample is not above the overvoltage limit, then on the sampling edge the reference takes the sampled value and the driver enable goes to 1.
- R4: When the sample is at or below the target, with D = target − sample and N = ramp setting (0 is treated as 1), the reference k edges after sampling equals sample + floor(D·k/N) for k = 1..N. It therefore equals the target at k = N and holds there afterwards.
- R5: Power-good rises on the edge N edges after sampling, and not earlier, provided the output code is not above the limit on that edge. Once high, it stays high while enable is high.
- R6: When the sample is above the target and not above the limit, the reference stays at the sampled value for N edges after sampling, with the drivers on and power-good low.
- R7: In the above-target case, with D = sample − target, the reference k edges after power-good rises equals sample − floor(D·k/N) for k = 1..N. It then holds at the target.
- R8: If the sample is strictly above the limit (a sample equal to the limit is accepted), the fault output pulses high for exactly one cycle on the sampling edge. The drivers and power-good stay low and the reference stays 0 until enable is dropped.
- R9: If the output code is above the limit on the edge that closes the ramp window, the fault output pulses for one cycle, power-good stays low, and the drivers and reference go to 0.
- R10: One edge after enable is seen low, whatever the state, the reference, driver enable, power-good and fault outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Start-up enable; low returns the block to idle |
| target_i | input | CODE_W | Programmed output target code |
| ramp_i | input | RAMP_W | Ramp window length in cycles (0 acts as 1) |
| delay_i | input | DLY_W | Turn-on delay in cycles |
| ov_limit_i | input | CODE_W | Overvoltage limit code |
| vout_i | input | CODE_W | Digitized output voltage |
| vref_o | output | CODE_W | Reference code sent to the regulation loop |
| drv_en_o | output | 1 | Enable for both power-stage drivers |
| pgood_o | output | 1 | Power-good |
| ov_fault_o | output | 1 | One-cycle overvoltage fault pulse |

## Verification
Two events can land on the same edge: the closing of the ramp window, which would raise power-good, and the overvoltage check of the live output, which must block it. The bench provokes this by pushing the output code above the limit on the last cycle of a rising ramp. The result passes only if that edge yields a one-cycle fault pulse, power-good never rises, and the drivers turn off. A second overlap, a sample exactly at the limit on the sampling edge, is judged by requiring the accept path rather than a fault.

// File: rtl/ssq_pkg.sv
// Shared types for the soft-start sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ssq_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_DELAY = 3'd1,
        SQ_RAMP  = 3'd2,
        SQ_HOLD  = 3'd3,
        SQ_DOWN  = 3'd4,
        SQ_REG   = 3'd5,
        SQ_FAULT = 3'd6
    } ssq_state_e;

endpackage

// File: rtl/ssq_step_calc.sv
// Step planner: from the live sample and the target, works out the
// direction, the whole step per cycle (q) and the remainder (r) for a
// window of n cycles. The ramp setting 0 is mapped to 1.
// Assumes: the result is used only on the edge that samples vout.
module ssq_step_calc #(
    parameter int CODE_W = 12,
    parameter int RAMP_W = 16
) (
    input  logic [CODE_W-1:0] sample_i,
    input  logic [CODE_W-1:0] target_i,
    input  logic [RAMP_W-1:0] ramp_i,
    output logic              above_o,
    output logic [CODE_W-1:0] q_o,
    output logic [RAMP_W-1:0] r_o,
    output logic [RAMP_W-1:0] n_o
);
    localparam int DW = (CODE_W > RAMP_W) ? CODE_W : RAMP_W;

    logic [CODE_W-1:0] mag;
    logic [DW-1:0]     mag_ext;
    logic [DW-1:0]     n_ext;

    // Magnitude of the distance and the effective window length
    always_comb begin
        above_o = (sample_i > target_i);
        mag     = above_o ? (sample_i - target_i) : (target_i - sample_i);
        n_o     = (ramp_i == '0) ? RAMP_W'(1) : ramp_i;
        mag_ext = DW'(mag);
        n_ext   = DW'(n_o);
    end

    // Whole and fractional parts of the per-cycle step
    always_comb begin
        q_o = CODE_W'(mag_ext / n_ext);
        r_o = RAMP_W'(mag_ext % n_ext);
    end

endmodule

// File: rtl/ssq_step_accum.sv
// Fractional step accumulator: each advance adds r to an accumulator
// modulo n and emits q plus the carry, so n advances sum to q*n + r.
// Assumes: r < n, and q, r, n are stable while advancing.
module ssq_step_accum #(
    parameter int CODE_W = 12,
    parameter int RAMP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic [CODE_W-1:0] q_i,
    input  logic [RAMP_W-1:0] r_i,
    input  logic [RAMP_W-1:0] n_i,
    output logic [CODE_W-1:0] step_o
);
    localparam int AW = RAMP_W + 1;

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;
    logic          carry;

    // Next sum and carry-out of the remainder accumulator
    always_comb begin
        sum    = acc + AW'(r_i);
        carry  = (sum >= AW'(n_i));
        step_o = q_i + CODE_W'(carry);
    end

    // Accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            acc <= '0;
        end else if (adv_i) begin
            acc <= carry ? (sum - AW'(n_i)) : sum;
        end
    end

    // Remainder stays below the window length (keeps the R4 profile exact)
    p_acc_below_n_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc < AW'(n_i));

endmodule

// File: rtl/ssq_cycle_timer.sv
// Cycle timer: counts up while inc is high and flags when the count
// equals the limit. Clear has priority.
// Assumes: the limit is stable while a phase is being timed.
module ssq_cycle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt;

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt <= '0;
        end else if (inc_i) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Terminal count flag
    assign done_o = (cnt == limit_i);

    // Counting never runs past the limit (R2 / R5 window)
    p_no_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |-> (cnt < limit_i));

endmodule

// File: rtl/ssq_softstart.sv
// Pre-bias aware soft-start sequencer (top). Waits a turn-on delay,
// samples the output code, starts the reference from that sample and
// brings it to the target within a fixed window. It also rules on
// power-good and overvoltage. All outputs are registered.
// Assumes: target, ramp and limit settings are stable during a start-up.
module ssq_softstart
    import ssq_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int RAMP_W = 16,
    parameter int DLY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [CODE_W-1:0] target_i,
    input  logic [RAMP_W-1:0] ramp_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic [CODE_W-1:0] ov_limit_i,
    input  logic [CODE_W-1:0] vout_i,
    output logic [CODE_W-1:0] vref_o,
    output logic              drv_en_o,
    output logic              pgood_o,
    output logic              ov_fault_o
);
    localparam int CNT_W = (DLY_W > RAMP_W) ? DLY_W : RAMP_W;

    ssq_state_e        state;
    logic [CODE_W-1:0] q_r;
    logic [RAMP_W-1:0] r_r;
    logic [RAMP_W-1:0] n_r;

    logic              c_above;
    logic [CODE_W-1:0] c_q;
    logic [RAMP_W-1:0] c_r;
    logic [RAMP_W-1:0] c_n;
    logic [CODE_W-1:0] step;
    logic              t_done;
    logic              t_clr;
    logic [CNT_W-1:0]  t_limit;
    logic              a_clr;
    logic              a_adv;
    logic              ov_hit;
    logic              moving;

    ssq_step_calc #(.CODE_W(CODE_W), .RAMP_W(RAMP_W)) u_calc (
        .sample_i (vout_i),
        .target_i (target_i),
        .ramp_i   (ramp_i),
        .above_o  (c_above),
        .q_o      (c_q),
        .r_o      (c_r),
        .n_o      (c_n)
    );

    ssq_step_accum #(.CODE_W(CODE_W), .RAMP_W(RAMP_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (a_clr),
        .adv_i  (a_adv),
        .q_i    (q_r),
        .r_i    (r_r),
        .n_i    (n_r),
        .step_o (step)
    );

    ssq_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (t_clr),
        .inc_i   (!t_clr),
        .limit_i (t_limit),
        .done_o  (t_done)
    );

    // Timer and accumulator control for the current phase
    always_comb begin
        ov_hit  = (vout_i > ov_limit_i);
        moving  = (state == SQ_RAMP) || (state == SQ_DOWN);
        t_limit = (state == SQ_DELAY) ? CNT_W'(delay_i)
                                      : CNT_W'(n_r - RAMP_W'(1));
        t_clr   = !en_i || t_done || (state == SQ_IDLE) ||
                  (state == SQ_REG) || (state == SQ_FAULT);
        a_clr   = !en_i || !moving;
        a_adv   = moving;
    end

    // Sequencer state and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            state      <= SQ_IDLE;
            vref_o     <= '0;
            drv_en_o   <= 1'b0;
            pgood_o    <= 1'b0;
            ov_fault_o <= 1'b0;
            if (!rst_n) begin
                q_r <= '0;
                r_r <= '0;
                n_r <= RAMP_W'(1);
            end
        end else begin
            ov_fault_o <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    state <= SQ_DELAY;
                end
                SQ_DELAY: begin
                    if (t_done) begin
                        if (ov_hit) begin
                            state      <= SQ_FAULT;
                            ov_fault_o <= 1'b1;
                        end else begin
                            q_r      <= c_q;
                            r_r      <= c_r;
                            n_r      <= c_n;
                            vref_o   <= vout_i;
                            drv_en_o <= 1'b1;
                            state    <= c_above ? SQ_HOLD : SQ_RAMP;
                        end
                    end
                end
                SQ_RAMP: begin
                    if (t_done && ov_hit) begin
                        state      <= SQ_FAULT;
                        ov_fault_o <= 1'b1;
                        drv_en_o   <= 1'b0;
                        vref_o     <= '0;
                    end else begin
                        vref_o <= vref_o + step;
                        if (t_done) begin
                            state   <= SQ_REG;
                            pgood_o <= 1'b1;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (t_done) begin
                        if (ov_hit) begin
                            state      <= SQ_FAULT;
                            ov_fault_o <= 1'b1;
                            drv_en_o   <= 1'b0;
                            vref_o     <= '0;
                        end else begin
                            state   <= SQ_DOWN;
                            pgood_o <= 1'b1;
                        end
                    end
                end
                SQ_DOWN: begin
                    vref_o <= vref_o - step;
                    if (t_done) begin
                        state <= SQ_REG;
                    end
                end
                SQ_REG: begin
                    state <= SQ_REG;
                end
                SQ_FAULT: begin
                    state <= SQ_FAULT;
                end
                default: begin
                    state <= SQ_IDLE;
                end
            endcase
        end
    end

    // R5: power-good is only ever shown with the drivers running
    p_pg_with_drv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_o |-> drv_en_o);

    // R5: once raised, power-good persists while enabled
    p_pg_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pgood_o && en_i) |=> pgood_o);

    // R8: fault is a single-cycle pulse
    p_fault_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ov_fault_o |=> !ov_fault_o);

    // R8 / R9: a fault never coexists with drive or power-good
    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ov_fault_o |-> (!drv_en_o && !pgood_o && vref_o == '0));

    // R10: enable low empties every output on the next edge
    p_en_low_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!drv_en_o && !pgood_o && !ov_fault_o && vref_o == '0));

    // R4: the rising ramp never moves down before its deadline
    p_ramp_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_RAMP && en_i && !t_done) |=> (vref_o >= $past(vref_o)));

    // R6: the reference is frozen while holding at the pre-bias level
    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_HOLD && en_i && !t_done) |=> $stable(vref_o));

    // R4 / R7: the regulated reference does not drift
    p_reg_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_REG && en_i) |=> $stable(vref_o));

endmodule

// File: tb/ssq_softstart_tb.sv
`timescale 1ns/1ps
module ssq_softstart_tb;
    localparam int CODE_W = 12;
    localparam int RAMP_W = 16;
    localparam int DLY_W  = 16;
    localparam int NV     = 8;

    // Vector table: target, pre-bias, limit, delay, ramp
    localparam int V_TGT [NV] = '{1000, 2000,  800, 1000, 1000, 1000, 3000, 4000};
    localparam int V_PRE [NV] = '{   0, 1500,  800, 1100, 1150, 1151,  100,    3};
    localparam int V_OV  [NV] = '{1150, 2300,  920, 1150, 1150, 1150, 3450, 4095};
    localparam int V_DLY [NV] = '{   3,    0,    2,    1,    2,    2,    4,    1};
    localparam int V_RMP [NV] = '{   7,   10,    4,    6,    5,    5,    0,   13};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [CODE_W-1:0] target = '0;
    logic [RAMP_W-1:0] ramp = '0;
    logic [DLY_W-1:0]  dly = '0;
    logic [CODE_W-1:0] ovl = '0;
    logic [CODE_W-1:0] vout = '0;
    logic [CODE_W-1:0] vref;
    logic              drv;
    logic              pg;
    logic              flt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ssq_softstart #(.CODE_W(CODE_W), .RAMP_W(RAMP_W), .DLY_W(DLY_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .target_i   (target),
        .ramp_i     (ramp),
        .delay_i    (dly),
        .ov_limit_i (ovl),
        .vout_i     (vout),
        .vref_o     (vref),
        .drv_en_o   (drv),
        .pgood_o    (pg),
        .ov_fault_o (flt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check({req, " vref"}, int'(vref), 0);
        check({req, " drv"}, int'(drv), 0);
        check({req, " pg"}, int'(pg), 0);
        check({req, " flt"}, int'(flt), 0);
    endtask

    // Runs one start-up from idle and drops enable at the end
    task automatic run_vec(input int tgt, input int pre, input int ov,
                           input int d, input int rmp);
        int n;
        int junk;
        longint dd;
        n    = (rmp == 0) ? 1 : rmp;
        junk = (pre > 2048) ? pre - 1000 : pre + 1000;
        @(negedge clk);
        target = CODE_W'(tgt);
        ovl    = CODE_W'(ov);
        dly    = DLY_W'(d);
        ramp   = RAMP_W'(rmp);
        vout   = CODE_W'(junk);
        en     = 1'b1;
        for (int i = 1; i <= d + 1; i++) begin
            @(negedge clk);
            check("R2 delay vref", int'(vref), 0);
            check("R2 delay drv", int'(drv), 0);
            if (i == d + 1) vout = CODE_W'(pre);
        end
        @(negedge clk);
        if (pre > ov) begin
            check("R8 fault pulse", int'(flt), 1);
            check("R8 no drv", int'(drv), 0);
            check("R8 no pg", int'(pg), 0);
            @(negedge clk);
            check("R8 pulse ends", int'(flt), 0);
            for (int i = 0; i <= n; i++) begin
                @(negedge clk);
                check("R8 stays off pg", int'(pg), 0);
                check("R8 stays off drv", int'(drv), 0);
                check("R8 stays off vref", int'(vref), 0);
            end
        end else begin
            check("R3 start vref", int'(vref), pre);
            check("R3 drv on", int'(drv), 1);
            check("R5 pg low at start", int'(pg), 0);
            if (pre <= tgt) begin
                dd = longint'(tgt - pre);
                for (int k = 1; k <= n; k++) begin
                    @(negedge clk);
                    check("R4 ramp vref", int'(vref), pre + int'((dd * k) / n));
                    check("R5 pg timing", int'(pg), (k == n) ? 1 : 0);
                end
            end else begin
                for (int k = 1; k <= n; k++) begin
                    @(negedge clk);
                    check("R6 hold vref", int'(vref), pre);
                    check("R6 drv on", int'(drv), 1);
                    check("R5 pg timing", int'(pg), (k == n) ? 1 : 0);
                end
                dd = longint'(pre - tgt);
                for (int k = 1; k <= n; k++) begin
                    @(negedge clk);
                    check("R7 step down vref", int'(vref), pre - int'((dd * k) / n));
                    check("R7 pg held", int'(pg), 1);
                end
            end
            @(negedge clk);
            check("R4 settled vref", int'(vref), tgt);
            check("R5 pg held", int'(pg), 1);
        end
        en = 1'b0;
        @(negedge clk);
        check_idle("R10 disable");
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything off even with enable high
        en = 1'b1;
        vout = 12'd500;
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // Table walk
        for (int v = 0; v < NV; v++) begin
            run_vec(V_TGT[v], V_PRE[v], V_OV[v], V_DLY[v], V_RMP[v]);
        end

        // R9: overvoltage seen on the edge that closes the ramp window
        @(negedge clk);
        target = 12'd1000; ovl = 12'd1150; dly = '0; ramp = 16'd4;
        vout = 12'd200; en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R3 start vref (R9 case)", int'(vref), 200);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check("R4 ramp vref (R9 case)", int'(vref), 200 + (800 * k) / 4);
        end
        vout = 12'd1200;
        @(negedge clk);
        check("R9 fault pulse", int'(flt), 1);
        check("R9 pg blocked", int'(pg), 0);
        check("R9 drv off", int'(drv), 0);
        check("R9 vref cleared", int'(vref), 0);
        @(negedge clk);
        check("R9 pulse ends", int'(flt), 0);
        check("R9 pg stays low", int'(pg), 0);
        en = 1'b0;
        @(negedge clk);
        check_idle("R10 after fault");

        // R10: enable dropped in the middle of a ramp
        vout = 12'd100; target = 12'd900; ramp = 16'd8; dly = 16'd1;
        en = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 ramp running drv", int'(drv), 1);
        en = 1'b0;
        @(negedge clk);
        check_idle("R10 mid-ramp");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule